// File: doc/BRIEF.md
# ADC Conversion Clock Prescaler

This block produces the conversion clock enable for a successive-approximation ADC core. Four candidate clock sources arrive as single-cycle enable ticks in one system clock domain. A 2-bit select picks one of them. The chosen tick stream passes through a coarse predivider with ratios 1, 4, 32 or 64, and then through a fine divider with ratios 1 to 8. The result is a registered one-cycle conversion tick.

The source, predivide and divide settings are sampled from their inputs on every cycle in which the conversion-enable flag is low. While the flag is high the held settings are frozen, so reprogramming cannot disturb a running conversion. Whenever the held settings change, both divider counters restart. The first conversion tick after a change therefore comes a full new period later.

Top module: `adc_clk_prescaler`

## Requirements
- R1: The predivide code sets the coarse ratio: 0 gives 1, 1 gives 4, 2 gives 32 and 3 gives 64.
- R2: The fine divide code D (3 bits) gives a fine ratio of D+1, from 1 to 8.
- R3: With held settings P and D, exactly one conversion tick is produced per R1-ratio(P)×(D+1) ticks of the selected source, counted from the last settings change or reset.
- R4: Select code k (0 to 3) makes bit k of the source tick input the only source that is counted; ticks on the other three bits have no effect on the output.
- R5: Settings are loaded from the inputs on each clock edge at which conversion enable is 0; on an edge where it is 1 the held settings keep their value, whatever the setting inputs carry.
- R6: Synchronous active-high reset sets all held settings to 0 (source 0, overall divide 1) and clears the conversion tick and both counters.
- R7: A change of the held settings clears both counters on the same edge, and a source tick that arrives on that edge is discarded, so the next conversion tick follows a full new period.
- R8: With overall divide 1, every tick of the selected source yields a conversion tick, including ticks on back-to-back cycles.
- R9: The conversion tick is registered. It is high for exactly the one cycle after the clock edge that samples the source tick which completes the count, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick_i | input | 4 | Clock-enable ticks of the four candidate sources, bit k is source k |
| src_sel_i | input | 2 | Source select code |
| pre_code_i | input | 2 | Predivide code |
| div_code_i | input | 3 | Fine divide code (ratio = code + 1) |
| conv_en_i | input | 1 | Conversion enable; locks the settings while high |
| conv_tick_o | output | 1 | Single-cycle conversion clock tick |

## Verification
The bench walks all 32 predivide and divide pairs. In each pair the selected source ticks every other cycle while the other three tick on every cycle. A wrong mux index, a swapped predivide entry or an off-by-one fine count would move or add conversion ticks against the predicted cycles. It changes the setting inputs while enable is high and holds them there across reset. A design that leaks writes through the lock would start ticking at the wrong rate. It switches settings after a partial count, and a design that keeps stale counter contents would fire early. Back-to-back source ticks at divide 1 expose a design that drops or merges adjacent conversion ticks.

// File: rtl/adc_pscl_pkg.sv
package adc_pscl_pkg;

  localparam int NUM_SRC   = 4;
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int PRE_W     = 2;
  localparam int DIV_W     = 3;
  localparam int PRE_MAX   = 64;
  localparam int PRE_CNT_W = $clog2(PRE_MAX);

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } pscl_cfg_t;

  // coarse ratio for a predivide code
  function automatic int unsigned pre_ratio(input logic [PRE_W-1:0] code);
    case (code)
      2'd0:    pre_ratio = 1;
      2'd1:    pre_ratio = 4;
      2'd2:    pre_ratio = 32;
      default: pre_ratio = 64;
    endcase
  endfunction

endpackage

// File: rtl/pscl_cfg_lock.sv
module pscl_cfg_lock
  import adc_pscl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      conv_en,
  input  pscl_cfg_t cfg_in,
  output pscl_cfg_t cfg_q,
  output logic      chg
);

  // a load that alters the held settings
  assign chg = !conv_en && (cfg_in != cfg_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (!conv_en) begin
      cfg_q <= cfg_in;
    end
  end

endmodule

// File: rtl/pscl_tick_sel.sv
module pscl_tick_sel #(
  parameter int NSRC  = 4,
  parameter int SEL_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [NSRC-1:0] hit;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign hit[k] = ticks[k] && (sel == SEL_W'(k));
  end

  assign tick = |hit;

endmodule

// File: rtl/pscl_pre_div.sv
module pscl_pre_div
  import adc_pscl_pkg::*;
#(
  parameter int CODE_W = PRE_W,
  parameter int CNT_W  = PRE_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick_in,
  input  logic [CODE_W-1:0] code,
  output logic              tick_out,
  output logic [CNT_W-1:0]  cnt_o
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim      = CNT_W'(pre_ratio(code) - 1);
  assign tick_out = tick_in && (cnt == lim);
  assign cnt_o    = cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick_in) begin
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pscl_fine_div.sv
module pscl_fine_div #(
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick_in,
  input  logic [DW-1:0] code,
  output logic          fire,
  output logic [DW-1:0] cnt_o
);

  logic [DW-1:0] cnt;

  assign fire  = tick_in && (cnt == code);
  assign cnt_o = cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick_in) begin
      cnt <= (cnt == code) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler
  import adc_pscl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [SRC_W-1:0]   src_sel_i,
  input  logic [PRE_W-1:0]   pre_code_i,
  input  logic [DIV_W-1:0]   div_code_i,
  input  logic               conv_en_i,
  output logic               conv_tick_o
);

  pscl_cfg_t             cfg_in;
  pscl_cfg_t             cfg_q;
  logic                  chg;
  logic                  sel_tick;
  logic                  cnt_tick;
  logic                  pre_tick;
  logic                  fire;
  logic [PRE_CNT_W-1:0]  pre_cnt;
  logic [DIV_W-1:0]      div_cnt;

  assign cfg_in = '{src: src_sel_i, pre: pre_code_i, div: div_code_i};

  pscl_cfg_lock u_lock (
    .clk     (clk),
    .rst     (rst),
    .conv_en (conv_en_i),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q),
    .chg     (chg)
  );

  pscl_tick_sel #(.NSRC(NUM_SRC), .SEL_W(SRC_W)) u_sel (
    .ticks (src_tick_i),
    .sel   (cfg_q.src),
    .tick  (sel_tick)
  );

  // a tick coinciding with a settings change is dropped
  assign cnt_tick = sel_tick && !chg;

  pscl_pre_div #(.CODE_W(PRE_W), .CNT_W(PRE_CNT_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (chg),
    .tick_in  (cnt_tick),
    .code     (cfg_q.pre),
    .tick_out (pre_tick),
    .cnt_o    (pre_cnt)
  );

  pscl_fine_div #(.DW(DIV_W)) u_fine (
    .clk     (clk),
    .rst     (rst),
    .clr     (chg),
    .tick_in (pre_tick),
    .code    (cfg_q.div),
    .fire    (fire),
    .cnt_o   (div_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_tick_o <= 1'b0;
    end else begin
      conv_tick_o <= fire;
    end
  end

endmodule

// File: rtl/adc_clk_prescaler_chk.sv
module adc_clk_prescaler_chk
  import adc_pscl_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 conv_en,
  input logic                 conv_tick,
  input pscl_cfg_t            cfg_q,
  input logic                 chg,
  input logic                 sel_tick,
  input logic [PRE_CNT_W-1:0] pre_cnt,
  input logic [DIV_W-1:0]     div_cnt
);

  // R9
  tick_cause_chk: assert property (@(posedge clk) disable iff (rst)
    conv_tick |-> $past(sel_tick && !chg));

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(conv_en) |-> $stable(cfg_q));

  // R6
  reset_val_chk: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && !conv_tick && pre_cnt == '0 && div_cnt == '0));

  // R7
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    chg |=> (pre_cnt == '0 && div_cnt == '0));

  // R1
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(pre_cnt) < pre_ratio(cfg_q.pre));

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    div_cnt <= cfg_q.div);

  // R8
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.pre == '0 && cfg_q.div == '0 && sel_tick && !chg) |=> conv_tick);

endmodule

bind adc_clk_prescaler adc_clk_prescaler_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .conv_en   (conv_en_i),
  .conv_tick (conv_tick_o),
  .cfg_q     (cfg_q),
  .chg       (chg),
  .sel_tick  (sel_tick),
  .pre_cnt   (pre_cnt),
  .div_cnt   (div_cnt)
);

// File: tb/adc_clk_prescaler_tb_top.sv
module adc_clk_prescaler_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] src_tick;
  logic [1:0] src_sel;
  logic [1:0] pre_code;
  logic [2:0] div_code;
  logic       conv_en;
  logic       conv_tick;

  int    cyc = 0;
  int    n_run = 0;
  int    n_fail = 0;
  int    exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_clk_prescaler dut_i (
    .clk         (clk),
    .rst         (rst),
    .src_tick_i  (src_tick),
    .src_sel_i   (src_sel),
    .pre_code_i  (pre_code),
    .div_code_i  (div_code),
    .conv_en_i   (conv_en),
    .conv_tick_o (conv_tick)
  );

  function automatic int ratio_of(input int p, input int d);
    int pr;
    case (p)
      0: pr = 1;
      1: pr = 4;
      2: pr = 32;
      default: pr = 64;
    endcase
    return pr * (d + 1);
  endfunction

  // monitor: pop and compare each conversion tick
  always @(negedge clk) begin
    if (!rst && conv_tick) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9: unexpected tick at cycle %0d, expected none", cyc);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e != cyc) begin
          n_fail++;
          $display("FAIL %s: tick at cycle %0d, expected cycle %0d", t, cyc, e);
        end
      end
    end
  end

  // driver: selected source ticks every other cycle (or every cycle when
  // dense), the other three tick every cycle
  task automatic drive_ticks(input int sel, input int n, input int ratio,
                             input bit dense, input string tag);
    int k = 0;
    for (int i = 0; i < (dense ? n : 2 * n); i++) begin
      logic on;
      @(negedge clk);
      on = dense || (i % 2 == 1);
      src_tick = 4'hF;
      src_tick[sel] = on;
      if (on) begin
        k++;
        if (k % ratio == 0) begin
          exp_q.push_back(cyc + 1);
          tag_q.push_back(tag);
        end
      end
    end
    @(negedge clk);
    src_tick = 4'h0;
    repeat (3) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d ticks missing, expected 0 pending", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic apply_cfg(input int s, input int p, input int d);
    @(negedge clk);
    src_tick = 4'h0;
    conv_en  = 1'b0;
    src_sel  = 2'(s);
    pre_code = 2'(p);
    div_code = 3'(d);
    repeat (2) @(negedge clk);
    conv_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst      = 1'b1;
    conv_en  = 1'b1;
    src_tick = 4'h0;
    src_sel  = 2'd3;
    pre_code = 2'd3;
    div_code = 3'd7;
    repeat (4) @(negedge clk);
    // R6: reset state, nonzero inputs locked out by enable
    n_run++;
    if (conv_tick !== 1'b0) begin
      n_fail++;
      $display("FAIL R6: conv_tick=%b during reset, expected 0", conv_tick);
    end
    rst = 1'b0;
    drive_ticks(0, 5, 1, 1'b0, "R6");

    // R1 R2 R3 R4: every predivide and divide pair, rotating the source
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 8; d++) begin
        int s;
        int r;
        s = (p * 8 + d) % 4;
        r = ratio_of(p, d);
        apply_cfg(s, p, d);
        drive_ticks(s, 2 * r, r, 1'b0, "R1 R2 R3 R4");
      end
    end

    // R5: writes while enabled are ignored
    apply_cfg(1, 0, 2);
    drive_ticks(1, 3, 3, 1'b0, "R5");
    @(negedge clk);
    src_sel  = 2'd2;
    pre_code = 2'd3;
    div_code = 3'd7;
    drive_ticks(1, 6, 3, 1'b0, "R5");

    // R7: settings change after a partial count restarts the period
    apply_cfg(2, 1, 0);
    drive_ticks(2, 2, 4, 1'b0, "R7");
    apply_cfg(2, 1, 1);
    drive_ticks(2, 8, 8, 1'b0, "R7");

    // R8 R9: divide 1 with back-to-back source ticks
    apply_cfg(3, 0, 0);
    drive_ticks(3, 6, 1, 1'b1, "R8 R9");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule